// File: doc/BRIEF.md
# Setup Packet Capture Buffer

This block holds the eight-byte setup stage of control endpoint 0. It sits between the USB-side receive logic and a CPU register interface. The receive logic pulses `usb_start` when a new setup transaction begins. It then delivers the payload one byte per `usb_wr_en` strobe. The eighth byte closes the capture and raises `setup_rcvd`.

The CPU pops bytes in order through a single data port, `cpu_rd`. Each pop returns the byte under an internal read index, one cycle later on `cpu_rdata`, and advances that index modulo eight.

Setup data must never be refused, so the USB side always wins. The write index is rearmed as soon as a new capture starts. Any CPU pop issued while a capture is open returns undefined data, and `cpu_rd_ok` stays low for that pop. The read index is never realigned by hardware. If software stops partway through a packet, the next packet comes back rotated. `overrun` records that this happened.

Top module: `setup_capture_buf`

## Requirements
- R1: After reset `capturing`, `setup_rcvd`, `overrun` and `cpu_rd_ok` are 0, the read index is 0 and all stored bytes are 0.
- R2: A `usb_start` pulse sets `capturing` and clears `setup_rcvd` at the next edge, and points the write index at byte 0. A `usb_wr_en` in the same cycle as `usb_start` is ignored.
- R3: Each `usb_wr_en` while `capturing` is 1 stores `usb_wr_data` at the next byte, in order from byte 0 to byte 7. A `usb_wr_en` while `capturing` is 0 leaves the stored bytes unchanged.
- R4: The write of byte 7 clears `capturing` and sets `setup_rcvd` at that edge. Before byte 7, `setup_rcvd` stays 0.
- R5: A `cpu_rd` pulse presents the byte under the read index on `cpu_rdata` in the following cycle. It also advances the index by one, wrapping from 7 to 0.
- R6: A `cpu_rd` issued while `capturing` is 1 still advances the read index. `cpu_rd_ok` is 0 in the following cycle, and `cpu_rdata` is undefined (X when `X_ON_COLLIDE` is 1, zero otherwise).
- R7: A `cpu_rd` issued while `capturing` is 0 gives `cpu_rd_ok` = 1 for exactly the following cycle. `cpu_rd_ok` is 0 in any cycle not preceded by a `cpu_rd`.
- R8: `usb_start` sets `overrun` when the read index is not 0, which means the previous packet was only partly read. With the index at 0, `overrun` is unchanged.
- R9: `cpu_clr_rcvd` and `cpu_clr_ovr` clear their flags at the next edge, acting as write-one-to-clear. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usb_start | input | 1 | Begin capture of a new setup packet |
| usb_wr_en | input | 1 | Byte write strobe from the USB receive side |
| usb_wr_data | input | DATA_W | Byte to store |
| cpu_rd | input | 1 | Pop one byte from the data port |
| cpu_clr_rcvd | input | 1 | Write-one-to-clear for `setup_rcvd` |
| cpu_clr_ovr | input | 1 | Write-one-to-clear for `overrun` |
| cpu_rdata | output | DATA_W | Byte returned by the previous pop |
| cpu_rd_ok | output | 1 | Previous pop returned defined data |
| capturing | output | 1 | Capture in progress |
| setup_rcvd | output | 1 | Full setup packet stored |
| overrun | output | 1 | New capture started over a partly read packet |

## Verification
A slipped write index shows up at the port as a byte in the wrong position, seen on the pop after the capture closes. It also shows up as a `setup_rcvd` that rises one write early or late. A read index that is stepped, wrapped or reset wrongly shows as a byte mismatch on the very next pop. The rotated readback after a partial read proves the index survives a new capture. A flag that sets or clears on the wrong event is visible one edge after the offending pulse, on `setup_rcvd`, `overrun` or `cpu_rd_ok`.

// File: rtl/scb_pkg.sv
package scb_pkg;
   // Index width for a buffer of n bytes, never less than one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   typedef struct packed {
      logic rcvd;
      logic ovr;
   } scb_flags_t;
endpackage

// File: rtl/scb_store.sv
module scb_store #(
   parameter int unsigned BYTES  = 8,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IW     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IW-1:0]     rd_idx,
   output logic              capturing,
   output logic              done,
   output logic [DATA_W-1:0] rd_byte
);
   localparam logic [IW-1:0] LAST = IW'(BYTES - 1);

   logic [IW-1:0]     wr_idx;
   logic              wr_go;
   logic [DATA_W-1:0] cells [BYTES];

   assign wr_go = capturing && wr_en && !start;
   assign done  = wr_go && (wr_idx == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_idx    <= '0;
         capturing <= 1'b0;
      end else if (start) begin
         wr_idx    <= '0;
         capturing <= 1'b1;
      end else if (wr_go) begin
         wr_idx <= wr_idx + 1'b1;
         if (wr_idx == LAST) capturing <= 1'b0;
      end
   end

   for (genvar g = 0; g < BYTES; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (!rst_n)
            cells[g] <= '0;
         else if (wr_go && (wr_idx == IW'(g)))
            cells[g] <= wr_data;
      end
   end

   assign rd_byte = cells[rd_idx];
endmodule

// File: rtl/scb_rd_port.sv
module scb_rd_port #(
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned IW           = 3,
   parameter bit          X_ON_COLLIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              capturing,
   input  logic [DATA_W-1:0] rd_byte,
   output logic [IW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_ok
);
   logic [DATA_W-1:0] junk;

   if (X_ON_COLLIDE) begin : g_xfill
      assign junk = 'x;
   end else begin : g_zfill
      assign junk = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_idx <= '0;
         rdata  <= '0;
         rd_ok  <= 1'b0;
      end else begin
         rd_ok <= rd && !capturing;
         if (rd) begin
            rd_idx <= rd_idx + 1'b1;
            rdata  <= capturing ? junk : rd_byte;
         end
      end
   end
endmodule

// File: rtl/scb_flags.sv
module scb_flags (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              done,
   input  logic              rd_partial,
   input  logic              clr_rcvd,
   input  logic              clr_ovr,
   output scb_pkg::scb_flags_t flags
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         if (done)          flags.rcvd <= 1'b1;
         else if (start)    flags.rcvd <= 1'b0;
         else if (clr_rcvd) flags.rcvd <= 1'b0;

         if (start && rd_partial) flags.ovr <= 1'b1;
         else if (clr_ovr)        flags.ovr <= 1'b0;
      end
   end
endmodule

// File: rtl/setup_capture_buf.sv
module setup_capture_buf #(
   parameter int unsigned BYTES        = 8,
   parameter int unsigned DATA_W       = 8,
   parameter bit          X_ON_COLLIDE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              usb_start,
   input  logic              usb_wr_en,
   input  logic [DATA_W-1:0] usb_wr_data,
   input  logic              cpu_rd,
   input  logic              cpu_clr_rcvd,
   input  logic              cpu_clr_ovr,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_rd_ok,
   output logic              capturing,
   output logic              setup_rcvd,
   output logic              overrun
);
   localparam int unsigned IW = scb_pkg::idx_w(BYTES);

   if (BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_bytes
      $error("setup_capture_buf: BYTES must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("setup_capture_buf: DATA_W must be positive");
   end

   logic              done;
   logic [IW-1:0]     rd_idx;
   logic [DATA_W-1:0] rd_byte;
   scb_pkg::scb_flags_t flags;

   scb_store #(.BYTES(BYTES), .DATA_W(DATA_W), .IW(IW)) u_store (
      .clk(clk), .rst_n(rst_n), .start(usb_start), .wr_en(usb_wr_en),
      .wr_data(usb_wr_data), .rd_idx(rd_idx), .capturing(capturing),
      .done(done), .rd_byte(rd_byte)
   );

   scb_rd_port #(.DATA_W(DATA_W), .IW(IW), .X_ON_COLLIDE(X_ON_COLLIDE)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(cpu_rd), .capturing(capturing),
      .rd_byte(rd_byte), .rd_idx(rd_idx), .rdata(cpu_rdata), .rd_ok(cpu_rd_ok)
   );

   scb_flags u_flags (
      .clk(clk), .rst_n(rst_n), .start(usb_start), .done(done),
      .rd_partial(rd_idx != '0), .clr_rcvd(cpu_clr_rcvd),
      .clr_ovr(cpu_clr_ovr), .flags(flags)
   );

   assign setup_rcvd = flags.rcvd;
   assign overrun    = flags.ovr;
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
   parameter int unsigned IW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          usb_start,
   input logic          usb_wr_en,
   input logic          cpu_rd,
   input logic          capturing,
   input logic          setup_rcvd,
   input logic          overrun,
   input logic          cpu_rd_ok,
   input logic [IW-1:0] rd_idx
);
   assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
      usb_start |=> (capturing && !setup_rcvd));

   assert_rcvd_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(setup_rcvd) |-> $past(capturing && usb_wr_en && !usb_start));

   assert_close_sets_rcvd_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(capturing) |-> setup_rcvd);

   assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> (rd_idx == IW'($past(rd_idx) + 1'b1)));

   assert_collide_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && capturing) |=> !cpu_rd_ok);

   assert_ok_needs_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd_ok |-> $past(cpu_rd));

   assert_ovr_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(usb_start));
endmodule

bind setup_capture_buf scb_checker #(.IW(IW)) u_chk (
   .clk(clk), .rst_n(rst_n), .usb_start(usb_start), .usb_wr_en(usb_wr_en),
   .cpu_rd(cpu_rd), .capturing(capturing), .setup_rcvd(setup_rcvd),
   .overrun(overrun), .cpu_rd_ok(cpu_rd_ok), .rd_idx(rd_idx)
);

// File: tb/setup_capture_buf_test.sv
`timescale 1ns/1ps
module setup_capture_buf_test;
   localparam int NPKT = 4;
   localparam logic [63:0] PKTS [NPKT] = '{
      64'h0000_0000_0001_0680, 64'h0000_0000_0005_0900,
      64'h1122_3344_5566_7788, 64'hFF00_FF00_A5A5_5A5A
   };

   logic clk = 0, rst_n = 0;
   logic usb_start = 0, usb_wr_en = 0, cpu_rd = 0, cpu_clr_rcvd = 0, cpu_clr_ovr = 0;
   logic [7:0] usb_wr_data = '0;
   logic [7:0] cpu_rdata;
   logic cpu_rd_ok, capturing, setup_rcvd, overrun;
   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   setup_capture_buf uut (
      .clk(clk), .rst_n(rst_n), .usb_start(usb_start), .usb_wr_en(usb_wr_en),
      .usb_wr_data(usb_wr_data), .cpu_rd(cpu_rd), .cpu_clr_rcvd(cpu_clr_rcvd),
      .cpu_clr_ovr(cpu_clr_ovr), .cpu_rdata(cpu_rdata), .cpu_rd_ok(cpu_rd_ok),
      .capturing(capturing), .setup_rcvd(setup_rcvd), .overrun(overrun)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   task automatic do_start();
      usb_start = 1; cyc(); usb_start = 0;
   endtask

   task automatic wr_byte(input logic [7:0] b);
      usb_wr_en = 1; usb_wr_data = b; cyc(); usb_wr_en = 0;
   endtask

   task automatic pop(output logic [7:0] d, output logic ok);
      cpu_rd = 1; cyc(); d = cpu_rdata; ok = cpu_rd_ok; cpu_rd = 0;
   endtask

   task automatic read_rotated(input logic [63:0] p, input int first, input string req);
      logic [7:0] d; logic ok;
      for (int i = 0; i < 8; i++) begin
         pop(d, ok);
         chk(req, d, p[8*((first+i)%8) +: 8]);
         chk("R7", ok, 1'b1);
      end
   endtask

   initial begin
      #800000;
      fails++;
      $display("FAIL R1: watchdog expired, actual hung expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] d; logic ok;
      repeat (3) cyc();
      chk("R1", {capturing, setup_rcvd, overrun, cpu_rd_ok}, 4'b0000);
      rst_n = 1; cyc();
      pop(d, ok);
      chk("R1", d, 8'h00);
      for (int i = 1; i < 8; i++) pop(d, ok);  // index back to 0

      // Table walk: capture, flag, clear, read back
      for (int k = 0; k < NPKT; k++) begin
         do_start();
         chk("R2", {capturing, setup_rcvd}, 2'b10);
         for (int i = 0; i < 7; i++) wr_byte(PKTS[k][8*i +: 8]);
         chk("R4", {capturing, setup_rcvd}, 2'b10);
         wr_byte(PKTS[k][63:56]);
         chk("R4", {capturing, setup_rcvd}, 2'b01);
         chk("R8", overrun, 1'b0);
         cpu_clr_rcvd = 1; cyc(); cpu_clr_rcvd = 0;
         chk("R9", setup_rcvd, 1'b0);
         read_rotated(PKTS[k], 0, "R5");
         cyc();
         chk("R7", cpu_rd_ok, 1'b0);
      end

      // R3: writes while idle change nothing
      repeat (3) wr_byte(8'hEE);
      read_rotated(PKTS[NPKT-1], 0, "R3");

      // R8: partial read, then new capture
      for (int i = 0; i < 3; i++) pop(d, ok);
      do_start();
      chk("R8", overrun, 1'b1);
      pop(d, ok);                              // collides with capture
      chk("R6", ok, 1'b0);
      for (int i = 0; i < 8; i++) wr_byte(PKTS[0][8*i +: 8]);
      read_rotated(PKTS[0], 4, "R5");          // index 4 after collision pop

      // R9: set beats clear on overrun; R2: write in start cycle ignored
      usb_start = 1; cpu_clr_ovr = 1; usb_wr_en = 1; usb_wr_data = 8'hAA;
      cyc();
      usb_start = 0; cpu_clr_ovr = 0; usb_wr_en = 0;
      chk("R9", overrun, 1'b1);
      cpu_clr_ovr = 1; cyc(); cpu_clr_ovr = 0;
      chk("R9", overrun, 1'b0);
      for (int i = 0; i < 7; i++) wr_byte(PKTS[2][8*i +: 8]);
      cpu_clr_rcvd = 1; wr_byte(PKTS[2][63:56]); cpu_clr_rcvd = 0;
      chk("R9", setup_rcvd, 1'b1);
      read_rotated(PKTS[2], 4, "R2");

      // R2: start clears a pending received flag
      do_start();
      chk("R2", {capturing, setup_rcvd}, 2'b10);

      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule